// File: doc/BRIEF.md
# UART Transmit Serializer

This block turns characters written by a host into an asynchronous serial bit stream. Each written character goes into a 16-entry holding FIFO. A frame engine takes characters from the FIFO one at a time and sends each one as a low start bit, then 5 to 8 data bits (least significant bit first), then an optional parity bit, then a stop interval of programmable length. All bit timing comes from a single-cycle enable pulse that an external divisor produces at sixteen times the baud rate, so every bit lasts sixteen such pulses.

The host sets character length, parity mode and stop length on static inputs. The engine latches these settings when it loads each character, so a change only affects later frames. A separate break input holds the line low for as long as it is asserted. Two status outputs report progress. One shows that nothing at all remains to send. The other is an interrupt-request level that rises once the FIFO has drained, even while the last character is still on the line.

Top module: `uart_tx_serializer`

## Requirements
- R1: After reset, and whenever no frame is being sent and break is not asserted, `txd` is high, `tx_empty` is 1 and `irq_fifo_empty` is 1.
- R2: A frame starts with `txd` low for exactly 16 baud ticks. The data bits follow least significant bit first, 16 ticks each. `char_len` selects the data length: 00=5, 01=6, 10=7, 11=8 bits. Upper data bits beyond that length are not sent.
- R3: With `parity_en`=1, one parity bit follows the data. With `parity_odd`=0 it makes the count of ones in the data and parity bits even. With `parity_odd`=1 it makes that count odd. With `parity_en`=0 no parity bit is sent.
- R4: The stop interval is high. It lasts 16 ticks when `stop_two`=0. When `stop_two`=1 it lasts 24 ticks for a 5-bit character and 32 ticks for any other length.
- R5: The frame length in ticks is 16*(1+data bits+parity bits) plus the stop ticks. When the FIFO holds another character at the end of a stop interval, the next start bit begins on that same tick, with no idle gap.
- R6: Characters leave in the order they were written. The FIFO holds 16 characters in addition to the one being shifted. A write while the FIFO is full is dropped, and the stored characters are sent unchanged.
- R7: `tx_empty` is 1 only when both the FIFO and the shift engine are empty. It is 0 from the cycle after an accepted write until the last stop interval ends.
- R8: `irq_fifo_empty` is 1 exactly when the FIFO holds no character, including while the last character is still being shifted.
- R9: While `break_force` is 1, `txd` is 0, whether the engine is idle or in the middle of a frame. When it is released, the line returns to the engine's level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable at 16x the baud rate |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DATA_W | Character to send |
| char_len | input | 2 | Data length code (00=5 .. 11=8) |
| parity_en | input | 1 | Parity bit enable |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| stop_two | input | 1 | Long stop interval (1.5 or 2 bits) |
| break_force | input | 1 | Hold the line low |
| txd | output | 1 | Serial output, idles high |
| tx_empty | output | 1 | FIFO and shift engine both empty |
| irq_fifo_empty | output | 1 | Interrupt-request level: FIFO empty |

## Verification
The bench decodes the line in the middle of each bit and measures each frame's length in ticks from the falling edge of its start bit. This catches a 5-bit, 1.5-stop frame that stretches to two full stop bits, as well as a back-to-back frame that inserts an idle tick or clips the stop interval. It covers every combination of length, parity and stop setting. A swapped even/odd sense or a bit order sent MSB first would show up as wrong bit values. It also overfills the FIFO while a character is being shifted. A FIFO that overwrites or wraps onto stored entries would then send the wrong sequence or extra frames. Break is asserted both while idle and in the middle of a frame, and the bench confirms that the status outputs separate a drained FIFO from a finished line.

// File: rtl/uart_tx_pkg.sv
// Shared definitions for the UART transmit serializer.
// Assumes: nothing beyond IEEE 1800-2017 package semantics.
package uart_tx_pkg;

    // Phases of one serial frame.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

endpackage

// File: rtl/uart_tx_fifo.sv
// Holding FIFO for characters waiting to be serialized.
// Shows the head entry combinationally (first word falls through).
// A write when full is dropped. A read when empty is ignored.
// Assumes: the reader only pops while not empty.
module uart_tx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CNTW-1:0]  count;
    logic             push;
    logic             pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign push    = wr_en && !full;
    assign pop     = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    // Store accepted characters at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Advance pointers and occupancy on accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (push && !pop) begin
                count <= count + 1'b1;
            end else if (pop && !push) begin
                count <= count - 1'b1;
            end
        end
    end

    // Occupancy never passes the depth (R6).
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // A write into a full FIFO with no read leaves occupancy unchanged (R6).
    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> $stable(count));

    // The frame engine never pops an empty FIFO (R6).
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);

endmodule

// File: rtl/uart_tx_frame_engine.sv
// Frame engine: loads one character at a time from the FIFO and drives start,
// data (LSB first), optional parity and stop levels, each timed in 16x ticks.
// Latches length, parity and stop settings when it loads a character.
// Loads the next character at the last stop tick, so frames leave no gap.
// Assumes: DATA_W is at least 8, so every 5..8 bit length fits.
module uart_tx_frame_engine
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic [1:0]        char_len,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              stop_two,
    output logic              fifo_pop,
    output logic              line,
    output logic              busy
);
    localparam int CW = $clog2(2 * OVS + 1);
    localparam int BW = $clog2(DATA_W) + 1;
    localparam logic [CW-1:0] BIT_TICKS  = CW'(OVS);
    localparam logic [CW-1:0] HALF_TICKS = CW'(OVS / 2);
    localparam logic [CW-1:0] MAX_CNT    = CW'(2 * OVS - 1);
    localparam logic [BW-1:0] MIN_BITS   = BW'(5);

    tx_state_t         state_q;
    logic [DATA_W-1:0] shreg_q;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     idx_q;
    logic [BW-1:0]     nbits_q;
    logic              par_en_q;
    logic              par_q;
    logic [CW-1:0]     stop_ticks_q;

    logic [CW-1:0]     limit;
    logic [CW-1:0]     cfg_stop;
    logic              bit_done;
    logic              load;

    // Tick count that ends the current bit, and the stop length for a new frame.
    always_comb begin
        limit = (state_q == ST_STOP) ? stop_ticks_q : BIT_TICKS;
        if (!stop_two) begin
            cfg_stop = BIT_TICKS;
        end else if (char_len == 2'b00) begin
            cfg_stop = BIT_TICKS + HALF_TICKS;
        end else begin
            cfg_stop = BIT_TICKS + BIT_TICKS;
        end
    end

    assign bit_done = tick && (cnt_q == limit - 1'b1);
    assign load     = !fifo_empty &&
                      ((state_q == ST_IDLE) || (state_q == ST_STOP && bit_done));
    assign fifo_pop = load;
    assign busy     = (state_q != ST_IDLE);

    // Line level for the current frame phase.
    always_comb begin
        unique case (state_q)
            ST_START:  line = 1'b0;
            ST_DATA:   line = shreg_q[0];
            ST_PARITY: line = par_q;
            default:   line = 1'b1;
        endcase
    end

    // Frame sequencing: load, count ticks, step through the bit phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            shreg_q      <= '0;
            cnt_q        <= '0;
            idx_q        <= '0;
            nbits_q      <= MIN_BITS;
            par_en_q     <= 1'b0;
            par_q        <= 1'b0;
            stop_ticks_q <= BIT_TICKS;
        end else if (load) begin
            state_q      <= ST_START;
            shreg_q      <= fifo_data;
            cnt_q        <= '0;
            idx_q        <= '0;
            nbits_q      <= MIN_BITS + BW'(char_len);
            par_en_q     <= parity_en;
            par_q        <= parity_odd;
            stop_ticks_q <= cfg_stop;
        end else if (tick && state_q != ST_IDLE) begin
            if (!bit_done) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
                unique case (state_q)
                    ST_START: state_q <= ST_DATA;
                    ST_DATA: begin
                        shreg_q <= shreg_q >> 1;
                        par_q   <= par_q ^ shreg_q[0];
                        idx_q   <= idx_q + 1'b1;
                        if (idx_q == nbits_q - 1'b1) begin
                            state_q <= par_en_q ? ST_PARITY : ST_STOP;
                        end
                    end
                    ST_PARITY: state_q <= ST_STOP;
                    default:   state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Tick counter stays inside the longest (two-bit) stop interval (R4).
    assert_tick_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MAX_CNT);

    // Data phase never indexes past the latched character length (R2).
    assert_bit_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (idx_q < nbits_q));

    // A frame ends only from the stop phase, leaving the line high (R5).
    assert_end_from_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(state_q) == ST_STOP) && line);

endmodule

// File: rtl/uart_tx_serializer.sv
// UART transmit serializer top: holding FIFO feeding the frame engine,
// with a break override on the serial line and two status outputs.
// Assumes: baud_tick is a single-cycle pulse at 16x the baud rate, and the
// format inputs are held steady while a character is being loaded.
module uart_tx_serializer #(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        char_len,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              stop_two,
    input  logic              break_force,
    output logic              txd,
    output logic              tx_empty,
    output logic              irq_fifo_empty
);
    logic [DATA_W-1:0] head_data;
    logic              fifo_empty;
    logic              fifo_full;
    logic              pop;
    logic              eng_line;
    logic              eng_busy;

    uart_tx_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (pop),
        .rd_data (head_data),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    uart_tx_frame_engine #(
        .DATA_W (DATA_W),
        .OVS    (OVERSAMPLE)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .fifo_empty (fifo_empty),
        .fifo_data  (head_data),
        .char_len   (char_len),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .stop_two   (stop_two),
        .fifo_pop   (pop),
        .line       (eng_line),
        .busy       (eng_busy)
    );

    // Break overrides the engine level; status combines FIFO and engine.
    assign txd            = break_force ? 1'b0 : eng_line;
    assign tx_empty       = fifo_empty && !eng_busy;
    assign irq_fifo_empty = fifo_empty;

    // Nothing pending and no break means the line sits high (R7).
    assert_empty_line_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !break_force) |-> txd);

    // A full FIFO can never coexist with an idle engine for a whole cycle (R6).
    assert_full_means_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> eng_busy);

endmodule

// File: tb/uart_tx_serializer_bench.sv
// Scoreboard bench: a driver queues the expected frames, and a line monitor
// decodes txd mid-bit and times each frame in baud ticks.
module uart_tx_serializer_bench;

    typedef struct {
        logic [7:0] d;
        int         n;
        bit         pe;
        bit         po;
        int         ticks;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] char_len = 2'b11;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       stop_two = 1'b0;
    logic       break_force = 1'b0;
    logic       txd;
    logic       tx_empty;
    logic       irq_fifo_empty;

    int   checks = 0;
    int   errors = 0;
    int   tick_cnt = 0;
    int   div_cnt = 0;
    bit   mon_en = 1'b0;
    bit   in_frame = 1'b0;
    exp_t expq[$];

    always #4 clk = ~clk;

    uart_tx_serializer u_uart_tx_serializer (
        .clk            (clk),
        .rst_n          (rst_n),
        .baud_tick      (baud_tick),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .char_len       (char_len),
        .parity_en      (parity_en),
        .parity_odd     (parity_odd),
        .stop_two       (stop_two),
        .break_force    (break_force),
        .txd            (txd),
        .tx_empty       (tx_empty),
        .irq_fifo_empty (irq_fifo_empty)
    );

    // Baud enable: one cycle in three, driven away from the active edge.
    always @(negedge clk) begin
        div_cnt   <= (div_cnt == 2) ? 0 : div_cnt + 1;
        baud_tick <= (div_cnt == 2);
    end

    // Count the ticks the design sees.
    always @(posedge clk) begin
        if (baud_tick) tick_cnt <= tick_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: write one character; when accept is set, expect it on the line.
    task automatic put(input logic [7:0] d, input bit accept);
        exp_t e;
        int nb;
        nb = 5 + int'(char_len);
        e.d = d;
        e.n = nb;
        e.pe = parity_en;
        e.po = parity_odd;
        e.ticks = 16 * (1 + nb + (parity_en ? 1 : 0)) +
                  (!stop_two ? 16 : (nb == 5 ? 24 : 32));
        if (accept) expq.push_back(e);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!(tx_empty && !in_frame) && guard < 20000);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: sample each bit in its middle and time the frame end.
    exp_t cur;
    int   t0 = 0;
    int   idx = 0;
    int   nbits_total = 0;
    bit   prev_txd = 1'b1;
    bit   prev_emp = 1'b1;
    always @(negedge clk) begin
        int bitexp;
        if (!rst_n || !mon_en) begin
            in_frame = 1'b0;
        end else begin
            if (in_frame && idx == nbits_total &&
                ((prev_txd && !txd) || (!prev_emp && tx_empty))) begin
                // R4 R5: stop length and total frame length in ticks
                check(tick_cnt - t0 == cur.ticks, "R4/R5 frame ticks", tick_cnt - t0, cur.ticks);
                in_frame = 1'b0;
            end
            if (!in_frame && prev_txd && !txd) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R6 unexpected frame", 1, 0);
                end else begin
                    cur = expq.pop_front();
                end
                t0 = tick_cnt;
                idx = 0;
                nbits_total = 2 + cur.n + (cur.pe ? 1 : 0);
                in_frame = 1'b1;
            end else if (in_frame && idx < nbits_total && tick_cnt - t0 == 8 + 16 * idx) begin
                if (idx == 0) begin
                    bitexp = 0;                           // R2 start bit
                end else if (idx <= cur.n) begin
                    bitexp = int'(cur.d[idx-1]);          // R2 data LSB first
                end else if (cur.pe && idx == cur.n + 1) begin
                    bitexp = int'(cur.po ^ (^(cur.d & 8'((1 << cur.n) - 1)))); // R3
                end else begin
                    bitexp = 1;                           // R4 stop level
                end
                check(int'(txd) == bitexp, idx == 0 ? "R2 start" :
                      (idx <= cur.n ? "R2 data bit" :
                      (idx == nbits_total - 1 ? "R4 stop level" : "R3 parity")),
                      int'(txd), bitexp);
                idx++;
            end
        end
        prev_txd = txd;
        prev_emp = tx_empty;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(txd == 1'b1, "R1 txd idle", int'(txd), 1);
        check(tx_empty == 1'b1, "R1 tx_empty", int'(tx_empty), 1);
        check(irq_fifo_empty == 1'b1, "R1 irq", int'(irq_fifo_empty), 1);
        mon_en = 1'b1;

        // R2 R3 R4 R5: sweep every format, two back-to-back frames each
        for (int len = 0; len < 4; len++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int st = 0; st < 2; st++) begin
                    char_len   = 2'(len);
                    parity_en  = (pm != 0);
                    parity_odd = (pm == 2);
                    stop_two   = st[0];
                    put(8'(8'hA5 ^ (len * 37 + pm * 11 + st * 3)), 1'b1);
                    put(8'(8'h3C + len * 5 + pm * 17 + st), 1'b1);
                    wait_idle();
                end
            end
        end

        // R7 R8: one character in flight, FIFO already drained
        char_len = 2'b11; parity_en = 1'b0; stop_two = 1'b0;
        put(8'h81, 1'b1);
        repeat (3) @(negedge clk);
        check(tx_empty == 1'b0, "R7 busy not empty", int'(tx_empty), 0);
        check(irq_fifo_empty == 1'b1, "R8 irq while shifting", int'(irq_fifo_empty), 1);
        wait_idle();
        check(tx_empty == 1'b1, "R7 empty after drain", int'(tx_empty), 1);

        // R6: overfill while one character is being shifted
        put(8'h00, 1'b1);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 18; i++) begin
            put(8'(8'h10 + i), i < 16);
        end
        check(irq_fifo_empty == 1'b0, "R8 irq low while holding", int'(irq_fifo_empty), 0);
        wait_idle();
        check(expq.size() == 0, "R6 all frames delivered", expq.size(), 0);

        // R9: break while idle
        mon_en = 1'b0;
        @(negedge clk);
        break_force = 1'b1;
        @(negedge clk);
        check(txd == 1'b0, "R9 break idle", int'(txd), 0);
        break_force = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R9 release idle", int'(txd), 1);

        // R9: break in the middle of a frame (stop bits are high)
        char_len = 2'b11; parity_en = 1'b0; stop_two = 1'b1;
        put(8'hFF, 1'b0);
        repeat (3 * 16 * 9 + 10) @(negedge clk);   // inside the stop interval
        check(txd == 1'b1, "R4 stop high before break", int'(txd), 1);
        break_force = 1'b1;
        @(negedge clk);
        check(txd == 1'b0, "R9 break mid-frame", int'(txd), 0);
        break_force = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R9 release mid-frame", int'(txd), 1);
        wait_idle();
        check(tx_empty == 1'b1 && txd == 1'b1, "R1 idle after break", int'(txd), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule